// File: doc/BRIEF.md
# SHA-512 schedule sigma0 stage

This block performs the first, partial step of the SHA-512 message expansion on four schedule words in parallel. A 256-bit operand carries four consecutive 64-bit schedule words, with lane 0 in bits [63:0] and lane k in bits [64k+63:64k]. A second, 128-bit operand provides the word that follows them in its low qword. Lane k of the result is the sum of word k and the small-sigma0 function of word k+1. Lane 3 therefore takes its neighbour from the low qword of the narrow operand.

The result is only an intermediate value. A later stage adds the sigma1 terms and the word from seven places earlier to finish the new schedule words. Operands arrive on a valid/ready handshake. One register stage holds each result until the consumer takes it. A parameter can remove that stage, which leaves a purely combinational path that still has the same handshake.

Top module: `sched_s0_stage`

## Requirements
- R1: Output lane k (bits [64k+63:64k], k = 0..3) equals input lane k plus sigma0 of input lane k+1. The word after lane 3 is bits [63:0] of `in_next`.
- R2: sigma0(x) is the XOR of x rotated right by 1, x rotated right by 8, and x shifted right logically by 7 with zero fill.
- R3: Bits [127:64] of `in_next` have no effect on any output.
- R4: Each lane sum is taken modulo 2^64. A carry out of a lane is discarded and never reaches the next lane.
- R5: While `rst` is high at a rising edge, `out_valid` is low after that edge.
- R6: `in_ready` is high whenever `out_valid` is low or `out_ready` is high.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_words` holds its value on the next cycle.
- R8: An operand accepted at a rising edge (`in_valid` and `in_ready` both high) appears as a valid result right after that edge.
- R9: A result taken by the consumer with no new operand accepted at the same edge leaves `out_valid` low afterwards. With `out_ready` held high, one operand is accepted on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Stage can take an operand pair |
| in_words | input | 256 | Four schedule words, lane 0 in the low bits |
| in_next | input | 128 | Low qword is the word after lane 3; high qword is unused |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result |
| out_words | output | 256 | Four partial schedule words, lane 0 in the low bits |

## Verification
A wrong lane pairing or a wrong rotate amount shows up in `out_words` on the cycle right after the operand is accepted. Single-bit and all-ones vectors show which lane and which bit is at fault. A holding register that drops or overwrites its value is seen at the ports as a changed result, or as a lost or duplicated result, while `out_ready` is low. The bench's queue model notices this on the same cycle, because it compares validity, readiness and data on every clock.

// File: rtl/sched_s0_pkg.sv
package sched_s0_pkg;

   // Output stage variant chosen at elaboration.
   typedef enum logic [0:0] {
      STAGE_REG    = 1'b0,
      STAGE_BYPASS = 1'b1
   } stage_mode_e;

   localparam int unsigned DEF_WORD_W  = 64;
   localparam int unsigned DEF_LANES   = 4;
   localparam int unsigned DEF_ROT_A   = 1;
   localparam int unsigned DEF_ROT_B   = 8;
   localparam int unsigned DEF_SHIFT_C = 7;

endpackage

// File: rtl/sched_s0_mix.sv
module sched_s0_mix #(
   parameter int unsigned WORD_W  = sched_s0_pkg::DEF_WORD_W,
   parameter int unsigned ROT_A   = sched_s0_pkg::DEF_ROT_A,
   parameter int unsigned ROT_B   = sched_s0_pkg::DEF_ROT_B,
   parameter int unsigned SHIFT_C = sched_s0_pkg::DEF_SHIFT_C
) (
   input  logic [WORD_W-1:0] x,
   output logic [WORD_W-1:0] y
);

   if (ROT_A == 0 || ROT_A >= WORD_W) begin : g_bad_rot_a
      $error("sched_s0_mix: ROT_A must lie in 1..WORD_W-1");
   end
   if (ROT_B == 0 || ROT_B >= WORD_W) begin : g_bad_rot_b
      $error("sched_s0_mix: ROT_B must lie in 1..WORD_W-1");
   end
   if (SHIFT_C >= WORD_W) begin : g_bad_shift
      $error("sched_s0_mix: SHIFT_C must be below WORD_W");
   end

   logic [WORD_W-1:0] rot_a;
   logic [WORD_W-1:0] rot_b;
   logic [WORD_W-1:0] shr_c;

   // Each rotate is pure rewiring: the low bits move to the top.
   assign rot_a = {x[ROT_A-1:0], x[WORD_W-1:ROT_A]};
   assign rot_b = {x[ROT_B-1:0], x[WORD_W-1:ROT_B]};
   assign shr_c = x >> SHIFT_C;

   assign y = rot_a ^ rot_b ^ shr_c;

endmodule

// File: rtl/sched_s0_lanes.sv
module sched_s0_lanes #(
   parameter int unsigned WORD_W  = sched_s0_pkg::DEF_WORD_W,
   parameter int unsigned LANES   = sched_s0_pkg::DEF_LANES,
   parameter int unsigned ROT_A   = sched_s0_pkg::DEF_ROT_A,
   parameter int unsigned ROT_B   = sched_s0_pkg::DEF_ROT_B,
   parameter int unsigned SHIFT_C = sched_s0_pkg::DEF_SHIFT_C,
   localparam int unsigned VEC_W  = WORD_W * LANES
) (
   input  logic [VEC_W-1:0]  words,
   input  logic [WORD_W-1:0] tail_word,
   output logic [VEC_W-1:0]  sums
);

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [WORD_W-1:0] nbr;
      logic [WORD_W-1:0] mixed;

      // The neighbour of the top lane comes from the separate tail word.
      if (k == LANES - 1) begin : g_tail
         assign nbr = tail_word;
      end else begin : g_inner
         assign nbr = words[(k+1)*WORD_W +: WORD_W];
      end

      sched_s0_mix #(
         .WORD_W (WORD_W),
         .ROT_A  (ROT_A),
         .ROT_B  (ROT_B),
         .SHIFT_C(SHIFT_C)
      ) u_mix (
         .x(nbr),
         .y(mixed)
      );

      // Lane-wide add; the carry out of the lane is dropped.
      assign sums[k*WORD_W +: WORD_W] = words[k*WORD_W +: WORD_W] + mixed;
   end

endmodule

// File: rtl/sched_s0_hold.sv
module sched_s0_hold #(
   parameter int unsigned                DATA_W = 256,
   parameter sched_s0_pkg::stage_mode_e MODE   = sched_s0_pkg::STAGE_REG
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              up_valid,
   output logic              up_ready,
   input  logic [DATA_W-1:0] up_data,
   output logic              dn_valid,
   input  logic              dn_ready,
   output logic [DATA_W-1:0] dn_data
);

   if (MODE == sched_s0_pkg::STAGE_REG) begin : g_reg
      logic              full_q;
      logic [DATA_W-1:0] data_q;
      logic              take;

      assign up_ready = !full_q || dn_ready;
      assign take     = up_valid && up_ready;

      always_ff @(posedge clk) begin
         if (rst) begin
            full_q <= 1'b0;
         end else if (take) begin
            full_q <= 1'b1;
         end else if (dn_ready) begin
            full_q <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (take) begin
            data_q <= up_data;
         end
      end

      assign dn_valid = full_q;
      assign dn_data  = data_q;
   end else begin : g_bypass
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst;

      assign up_ready = dn_ready;
      assign dn_valid = up_valid;
      assign dn_data  = up_data;
   end

endmodule

// File: rtl/sched_s0_stage.sv
module sched_s0_stage #(
   parameter int unsigned                WORD_W  = sched_s0_pkg::DEF_WORD_W,
   parameter int unsigned                LANES   = sched_s0_pkg::DEF_LANES,
   parameter int unsigned                ROT_A   = sched_s0_pkg::DEF_ROT_A,
   parameter int unsigned                ROT_B   = sched_s0_pkg::DEF_ROT_B,
   parameter int unsigned                SHIFT_C = sched_s0_pkg::DEF_SHIFT_C,
   parameter sched_s0_pkg::stage_mode_e MODE    = sched_s0_pkg::STAGE_REG,
   localparam int unsigned               VEC_W   = WORD_W * LANES,
   localparam int unsigned               NEXT_W  = 2 * WORD_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [VEC_W-1:0]  in_words,
   input  logic [NEXT_W-1:0] in_next,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [VEC_W-1:0]  out_words
);

   if (LANES < 1) begin : g_bad_lanes
      $error("sched_s0_stage: LANES must be at least 1");
   end
   if (WORD_W < 2) begin : g_bad_width
      $error("sched_s0_stage: WORD_W must be at least 2");
   end

   logic [VEC_W-1:0] lane_sums;
   logic             unused_next_hi;

   // Only the low word of the narrow operand takes part.
   assign unused_next_hi = ^in_next[NEXT_W-1:WORD_W];

   sched_s0_lanes #(
      .WORD_W (WORD_W),
      .LANES  (LANES),
      .ROT_A  (ROT_A),
      .ROT_B  (ROT_B),
      .SHIFT_C(SHIFT_C)
   ) u_lanes (
      .words    (in_words),
      .tail_word(in_next[WORD_W-1:0]),
      .sums     (lane_sums)
   );

   sched_s0_hold #(
      .DATA_W(VEC_W),
      .MODE  (MODE)
   ) u_hold (
      .clk     (clk),
      .rst     (rst),
      .up_valid(in_valid),
      .up_ready(in_ready),
      .up_data (lane_sums),
      .dn_valid(out_valid),
      .dn_ready(out_ready),
      .dn_data (out_words)
   );

endmodule

// File: rtl/sched_s0_stage_chk.sv
module sched_s0_stage_chk #(
   parameter int unsigned                DATA_W = 256,
   parameter sched_s0_pkg::stage_mode_e MODE   = sched_s0_pkg::STAGE_REG
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_words
);

   if (MODE == sched_s0_pkg::STAGE_REG) begin : g_reg_checks
      assert_reset_clears_R5: assert property (@(posedge clk)
         rst |=> !out_valid);

      assert_ready_when_free_R6: assert property (@(posedge clk) disable iff (rst)
         (!out_valid || out_ready) |-> in_ready);

      assert_hold_valid_R7: assert property (@(posedge clk) disable iff (rst)
         (out_valid && !out_ready) |=> out_valid);

      assert_hold_data_R7: assert property (@(posedge clk) disable iff (rst)
         (out_valid && !out_ready) |=> $stable(out_words));

      assert_accept_shows_R8: assert property (@(posedge clk) disable iff (rst)
         (in_valid && in_ready) |=> out_valid);

      assert_drain_empties_R9: assert property (@(posedge clk) disable iff (rst)
         (out_valid && out_ready && !in_valid) |=> !out_valid);
   end

endmodule

bind sched_s0_stage sched_s0_stage_chk #(
   .DATA_W(VEC_W),
   .MODE  (MODE)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .out_valid(out_valid),
   .out_ready(out_ready),
   .out_words(out_words)
);

// File: tb/test_sched_s0_stage.sv
module test_sched_s0_stage;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 200000;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [255:0] in_words = '0;
   logic [127:0] in_next = '0;
   logic         out_valid;
   logic         out_ready = 1'b0;
   logic [255:0] out_words;

   logic [255:0] exp_q[$];
   int           n_cmp = 0;
   int           n_bad = 0;
   int           n_acc = 0;
   bit           done = 1'b0;
   string        tag = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   sched_s0_stage i_sched_s0_stage (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .in_words (in_words),
      .in_next  (in_next),
      .out_valid(out_valid),
      .out_ready(out_ready),
      .out_words(out_words)
   );

   // Behavioural sigma0 from the schedule definition.
   function automatic logic [63:0] ref_sig0(logic [63:0] x);
      logic [63:0] r1, r8, s7;
      r1 = (x >> 1) | (x << 63);
      r8 = (x >> 8) | (x << 56);
      s7 = x >> 7;
      return r1 ^ r8 ^ s7;
   endfunction

   function automatic logic [255:0] ref_out(logic [255:0] a, logic [127:0] b);
      logic [63:0]  w[5];
      logic [255:0] r;
      for (int i = 0; i < 4; i++) w[i] = a[64*i +: 64];
      w[4] = b[63:0];
      for (int i = 0; i < 4; i++) r[64*i +: 64] = w[i] + ref_sig0(w[i+1]);
      return r;
   endfunction

   function automatic logic [255:0] rnd256();
      logic [255:0] r;
      for (int i = 0; i < 8; i++) r[32*i +: 32] = $urandom();
      return r;
   endfunction

   task automatic check(input bit ok, input string rq, input logic [255:0] act,
                        input logic [255:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   // One cycle: drive at the falling edge, observe, and advance the model.
   task automatic step(input bit v, input logic [255:0] a, input logic [127:0] b,
                       input bit rdy);
      bit fire_in, fire_out, exp_rdy, exp_vld;
      @(negedge clk);
      in_valid  = v;
      in_words  = a;
      in_next   = b;
      out_ready = rdy;
      #1;
      exp_vld = (exp_q.size() != 0);
      exp_rdy = !exp_vld || rdy;
      check(in_ready == exp_rdy, "R6", {255'd0, in_ready}, {255'd0, exp_rdy});
      check(out_valid == exp_vld, "R8", {255'd0, out_valid}, {255'd0, exp_vld});
      if (out_valid && exp_vld)
         check(out_words === exp_q[0], tag, out_words, exp_q[0]);
      fire_out = out_valid && rdy;
      fire_in  = v && in_ready;
      if (fire_out && exp_q.size() != 0) void'(exp_q.pop_front());
      if (fire_in) begin
         exp_q.push_back(ref_out(a, b));
         n_acc++;
      end
   endtask

   task automatic do_reset(input int cycles);
      @(negedge clk);
      rst = 1'b1;
      in_valid = 1'b0;
      repeat (cycles) @(negedge clk);
      #1;
      check(out_valid == 1'b0, "R5", {255'd0, out_valid}, 256'd0);
      exp_q.delete();
      rst = 1'b0;
   endtask

   initial begin
      logic [255:0] a;
      logic [127:0] b;
      int           acc0;

      do_reset(3);

      // Single-bit neighbours exercise every rotate and shift position (R2).
      tag = "R2";
      for (int i = 0; i < 64; i++) begin
         b = '0;
         b[i] = 1'b1;
         step(1'b1, '0, b, 1'b1);
      end
      for (int i = 0; i < 64; i++) begin
         a = '0;
         a[64 + i] = 1'b1;
         step(1'b1, a, '0, 1'b1);
      end

      // One-hot lanes show the lane pairing (R1).
      tag = "R1";
      for (int k = 0; k < 4; k++) begin
         a = '0;
         a[64*k +: 64] = 64'h0123_4567_89AB_CDEF;
         step(1'b1, a, 128'h0, 1'b1);
         step(1'b1, a, {64'h0, 64'hFEDC_BA98_7654_3210}, 1'b1);
      end

      // All-ones and near-overflow words: carries wrap inside a lane (R4).
      tag = "R4";
      step(1'b1, {256{1'b1}}, {128{1'b1}}, 1'b1);
      step(1'b1, {4{64'hFFFF_FFFF_FFFF_FFFF}}, {64'h0, 64'h1}, 1'b1);
      step(1'b1, {4{64'h8000_0000_0000_0000}}, {64'h0, 64'h8000_0000_0000_0000}, 1'b1);

      // Upper qword of the narrow operand is changed, low qword kept (R3).
      tag = "R3";
      a = rnd256();
      for (int i = 0; i < 8; i++) begin
         b = {rnd256()}[127:0];
         b[63:0] = 64'hA5A5_5A5A_0F0F_F0F0;
         step(1'b1, a, b, 1'b1);
      end

      // Stalled consumer: result and validity must hold (R7).
      tag = "R7";
      step(1'b1, rnd256(), {rnd256()}[127:0], 1'b0);
      for (int i = 0; i < 6; i++) step(1'b1, rnd256(), {rnd256()}[127:0], 1'b0);
      step(1'b0, '0, '0, 1'b1);
      step(1'b0, '0, '0, 1'b1);

      // Full throughput with the consumer always ready (R9).
      tag = "R9";
      acc0 = n_acc;
      for (int i = 0; i < 20; i++) step(1'b1, rnd256(), {rnd256()}[127:0], 1'b1);
      check(n_acc - acc0 == 20, "R9", 256'(n_acc - acc0), 256'd20);
      step(1'b0, '0, '0, 1'b1);
      step(1'b0, '0, '0, 1'b1);

      // Random traffic on both sides of the handshake (R1).
      tag = "R1";
      for (int i = 0; i < 600; i++)
         step(($urandom() % 3) != 0, rnd256(), {rnd256()}[127:0], ($urandom() % 2) == 0);

      // Reset while a result is held (R5).
      step(1'b1, rnd256(), '0, 1'b0);
      do_reset(2);
      step(1'b0, '0, '0, 1'b1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule